// File: doc/BRIEF.md
# Memory Range Decoder Register Bank

This block holds the software-visible registers for a small set of host-managed memory range decoders. Software reaches it over a simple register bus that accepts only aligned 32-bit accesses. Each decoder has a base address and a size, each split into a low and a high dword, plus a control register and a target list split into low and high dwords. Two global registers sit in front of the decoders. One is a read-only capability word that describes the bank. The other is a control register that carries the global enable.

Every stored register has a fixed write mask. On a write, only the bits inside the mask take the new data, and all other bits keep their stored value. Software cannot write a decoder's committed and error flags directly. Instead, any write to a decoder control register runs a commit handshake: the commit-request bit of the written value sets or clears the committed flag, and the error flag is cleared in both cases. The bank does no address translation itself; it only stores the programming that downstream decode logic consumes.

Top module: `mem_dec_regs`

## Requirements
- R1: After reset, the capability word reads 0x0000_0312 with the default four decoders, and every other mapped register reads zero, including the global enable.
- R2: Only dword accesses are serviced. A read with `wide_i` high returns zero with `rvalid_o` still asserted, and a write with `wide_i` high changes no register.
- R3: A dword write stores (wdata AND mask) OR (old AND NOT mask) into the addressed register.
- R4: Any write to a decoder control register whose bit 9 (commit request) is 1 leaves bit 10 (committed) at 1 and bit 11 (error) at 0 in the following cycle. Nothing else changes bits 10 and 11.
- R5: Any write to a decoder control register whose bit 9 is 0 leaves both bit 10 and bit 11 at 0 in the following cycle.
- R6: Decoder n occupies byte offsets 0x10+0x20*n onward, with word slots +0x00 base-low (mask 0xF000_0000), +0x04 base-high (0xFFFF_FFFF), +0x08 size-low (0xF000_0000), +0x0C size-high (0xFFFF_FFFF), +0x10 control (0x0000_13FF), +0x14 target-list-low, and +0x18 target-list-high (0xFFFF_FFFF).
- R7: The target-list-low mask is 0xF000_0000 when the `IS_ENDPOINT` parameter is 1, and 0xFFFF_FFFF when it is 0.
- R8: The capability word at offset 0x00 is read-only and holds the following fields:
  - bits [3:0]: the decoder-count code, with counts 1,2,4,6,8,10,12,14,16,20,24,28,32 mapping to codes 0 through 0xC;
  - bits [7:4]: target count, which reads 1;
  - bit 8: 256-byte interleave support, which reads 1;
  - bit 9: 4-KiB interleave support, which reads 1;
  - bit 10: poison-on-error support, which reads 0.
- R9: The global control register at offset 0x04 has write mask 0x0000_0003.
- R10: Reads of unmapped offsets return zero, and writes to unmapped offsets have no effect. The unmapped offsets are 0x08, 0x0C, each decoder's +0x1C slot, and everything past the last decoder.
- R11: `rvalid_o` and `rdata_o` are valid exactly one cycle after a read request. No write request produces `rvalid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 8-byte access (not serviced) |
| addr_i | input | ADDR_W | Byte address, dword aligned |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |

## Verification
The bench sweeps every dword offset of the address space and writes each one with four patterns:
- all ones, which exposes each register's mask exactly;
- 0x5A5A5A5A and 0xA5A5A5A5, complementary words whose bit 9 is 1 and 0 respectively, so they separate commit from uncommit as well as the kept bits from the written bits;
- all zeros.

After each pattern, every offset is read back against a bench model built from the mask rules. That read-back catches aliasing between registers and writes that land in unmapped slots. A final wide-write sweep followed by wide reads checks that 8-byte accesses leave the stored state untouched and read back zero.

// File: rtl/mdr_pkg.sv
package mdr_pkg;
  localparam int unsigned SLOT_REGS     = 8;   // word slots per decoder, last unused
  localparam int unsigned IDX_CTRL      = 4;
  localparam int unsigned IDX_TGT_LO    = 5;
  localparam int unsigned BIT_COMMIT    = 9;
  localparam int unsigned BIT_COMMITTED = 10;
  localparam int unsigned BIT_ERR       = 11;
  localparam int unsigned DEC_BASE_WORD = 4;   // decoders start at byte 0x10

  function automatic logic [3:0] count_code(int unsigned n);
    case (n)
      1: return 4'h0;   2: return 4'h1;   4: return 4'h2;   6: return 4'h3;
      8: return 4'h4;   10: return 4'h5;  12: return 4'h6;  14: return 4'h7;
      16: return 4'h8;  20: return 4'h9;  24: return 4'hA;  28: return 4'hB;
      32: return 4'hC;
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic [31:0] cap_word(int unsigned n);
    logic [31:0] c;
    c        = '0;
    c[3:0]   = count_code(n);
    c[7:4]   = 4'd1;
    c[8]     = 1'b1;
    c[9]     = 1'b1;
    c[10]    = 1'b0;
    return c;
  endfunction

  function automatic logic [31:0] slot_mask(int unsigned idx, bit is_ep);
    case (idx)
      0, 2:    return 32'hF000_0000;
      1, 3, 6: return 32'hFFFF_FFFF;
      4:       return 32'h0000_13FF;
      5:       return is_ep ? 32'hF000_0000 : 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] wd, logic [31:0] m);
    return (wd & m) | (old & ~m);
  endfunction
endpackage

// File: rtl/mdr_global_regs.sv
module mdr_global_regs #(
  parameter int unsigned NUM_DEC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        gctrl_wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] cap_o,
  output logic [31:0] gctrl_o
);
  import mdr_pkg::*;
  localparam logic [31:0] GCTRL_MASK = 32'h0000_0003;

  logic [31:0] gctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gctrl_q <= '0;
    else if (gctrl_wr_i) gctrl_q <= merge(gctrl_q, wdata_i, GCTRL_MASK);
  end

  assign cap_o   = cap_word(NUM_DEC);
  assign gctrl_o = gctrl_q;
endmodule

// File: rtl/mdr_dec_slot.sv
module mdr_dec_slot #(
  parameter bit IS_ENDPOINT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [2:0]  idx_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        committed_o,
  output logic        error_o
);
  import mdr_pkg::*;
  localparam int unsigned NREG = SLOT_REGS - 1;

  logic [31:0] regs_q [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam logic [31:0] MASK = slot_mask(r, IS_ENDPOINT);
    logic [31:0] nxt;
    always_comb begin
      nxt = merge(regs_q[r], wdata_i, MASK);
      if (r == IDX_CTRL) begin
        nxt[BIT_COMMITTED] = nxt[BIT_COMMIT];
        nxt[BIT_ERR]       = 1'b0;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[r] <= '0;
      else if (wr_i && idx_i == 3'(r))   regs_q[r] <= nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NREG; r++)
      if (idx_i == 3'(r)) rdata_o = regs_q[r];
  end

  assign committed_o = regs_q[IDX_CTRL][BIT_COMMITTED];
  assign error_o     = regs_q[IDX_CTRL][BIT_ERR];
endmodule

// File: rtl/mem_dec_regs.sv
module mem_dec_regs #(
  parameter int unsigned NUM_DEC     = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter bit          IS_ENDPOINT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  import mdr_pkg::*;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned SLOT_W = WORD_W - 3;

  logic [WORD_W-1:0] word, rel;
  logic [SLOT_W-1:0] slot;
  logic [2:0]        idx;
  logic              in_dec, dw_wr, rd_req;
  logic              unused_lsb;
  logic [31:0]       cap, gctrl, rd_mux;
  logic [31:0]       slot_rd [NUM_DEC];
  logic [NUM_DEC-1:0] dec_committed, dec_error, slot_hit;

  assign unused_lsb = ^addr_i[1:0];
  assign word   = addr_i[ADDR_W-1:2];
  assign in_dec = word >= WORD_W'(DEC_BASE_WORD);
  assign rel    = word - WORD_W'(DEC_BASE_WORD);
  assign slot   = rel[WORD_W-1:3];
  assign idx    = rel[2:0];
  assign dw_wr  = req_i & we_i & ~wide_i;
  assign rd_req = req_i & ~we_i;

  mdr_global_regs #(.NUM_DEC(NUM_DEC)) i_glob (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gctrl_wr_i(dw_wr && word == WORD_W'(1)),
    .wdata_i   (wdata_i),
    .cap_o     (cap),
    .gctrl_o   (gctrl)
  );

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
    assign slot_hit[k] = in_dec && slot == SLOT_W'(k);
    mdr_dec_slot #(.IS_ENDPOINT(IS_ENDPOINT)) i_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (dw_wr && slot_hit[k]),
      .idx_i      (idx),
      .wdata_i    (wdata_i),
      .rdata_o    (slot_rd[k]),
      .committed_o(dec_committed[k]),
      .error_o    (dec_error[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (word == WORD_W'(0))      rd_mux = cap;
    else if (word == WORD_W'(1)) rd_mux = gctrl;
    for (int k = 0; k < NUM_DEC; k++)
      if (slot_hit[k]) rd_mux = slot_rd[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= wide_i ? 32'h0 : rd_mux;
    end
  end
endmodule

// File: rtl/mem_dec_regs_chk.sv
module mem_dec_regs_chk #(
  parameter int unsigned NUM_DEC = 4,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic               wide_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               rvalid_o,
  input logic [31:0]        rdata_o,
  input logic [NUM_DEC-1:0] dec_committed,
  input logic [NUM_DEC-1:0] dec_error
);
  localparam logic [ADDR_W-1:0] CTRL0 = ADDR_W'(32'h20);
  logic ctrl0_wr, rd;
  assign ctrl0_wr = req_i && we_i && !wide_i && addr_i == CTRL0;
  assign rd       = req_i && !we_i;

  p_commit_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl0_wr && wdata_i[9] |=> dec_committed[0] && !dec_error[0]);
  p_uncommit_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl0_wr && !wdata_i[9] |=> !dec_committed[0] && !dec_error[0]);
  p_status_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl0_wr |=> $stable(dec_committed[0]) && $stable(dec_error[0]));
  p_read_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  p_no_spurious_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  p_wide_read_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && wide_i |=> rdata_o == 32'h0);
endmodule

bind mem_dec_regs mem_dec_regs_chk #(.NUM_DEC(NUM_DEC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .wide_i(wide_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
  .dec_committed(dec_committed), .dec_error(dec_error)
);

// File: tb/test_mem_dec_regs.sv
module test_mem_dec_regs;
  localparam int ADDR_W = 8;
  localparam int NWORD  = 1 << (ADDR_W - 2);

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0, wide = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  int errors = 0, checks = 0;
  logic [31:0] exp_q [NWORD];
  bit done = 0;

  always #5 clk = ~clk;

  mem_dec_regs i_mem_dec_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  function automatic bit mapped(int w);
    if (w < 2) return 1;
    if (w < 4) return 0;
    return ((w - 4) / 8 < 4) && ((w - 4) % 8 != 7);
  endfunction

  function automatic logic [31:0] mask_of(int w);
    if (w == 0) return 32'h0;
    if (w == 1) return 32'h3;
    if (!mapped(w)) return 32'h0;
    case ((w - 4) % 8)
      0, 2:    return 32'hF000_0000;
      4:       return 32'h0000_13FF;
      5:       return 32'hF000_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string tag_of(int w, bit ones);
    if (w == 0) return "R8";
    if (w == 1) return "R9";
    if (!mapped(w)) return "R10";
    case ((w - 4) % 8)
      4: return exp_q[w][10] ? "R4" : "R5";
      5: return "R7";
      default: return ones ? "R6" : "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv, int w);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s word 0x%02h: actual 0x%08h expected 0x%08h", tag, w * 4, act, expv);
    end
  endtask

  task automatic wr(int w, logic [31:0] d, bit wd);
    @(negedge clk);
    req = 1; we = 1; wide = wd; addr = ADDR_W'(w * 4); wdata = d;
    @(negedge clk);
    req = 0; we = 0; wide = 0;
    if (!wd) begin
      exp_q[w] = (d & mask_of(w)) | (exp_q[w] & ~mask_of(w));
      if (mapped(w) && w >= 4 && (w - 4) % 8 == 4) begin
        exp_q[w][10] = exp_q[w][9];
        exp_q[w][11] = 1'b0;
      end
    end
    check("R11", {31'b0, rvalid}, 32'h0, w);
  endtask

  task automatic rd(int w, bit wd, string tag);
    @(negedge clk);
    req = 1; we = 0; wide = wd; addr = ADDR_W'(w * 4);
    @(negedge clk);
    req = 0; wide = 0;
    check("R11", {31'b0, rvalid}, 32'h1, w);
    check(tag, rdata, wd ? 32'h0 : exp_q[w], w);
  endtask

  task automatic sweep(logic [31:0] d, bit ones);
    for (int w = 0; w < NWORD; w++) wr(w, d, 1'b0);
    for (int w = 0; w < NWORD; w++) rd(w, 1'b0, tag_of(w, ones));
  endtask

  initial begin
    for (int w = 0; w < NWORD; w++) exp_q[w] = '0;
    exp_q[0] = 32'h0000_0312;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    for (int w = 0; w < NWORD; w++) rd(w, 1'b0, "R1");
    sweep(32'hFFFF_FFFF, 1'b1);
    sweep(32'h5A5A_5A5A, 1'b0);
    sweep(32'hA5A5_A5A5, 1'b0);
    sweep(32'h5A5A_5A5A, 1'b0);
    for (int w = 0; w < NWORD; w++) wr(w, 32'h0000_0000, 1'b1);
    for (int w = 0; w < NWORD; w++) rd(w, 1'b0, "R2");
    for (int w = 0; w < 12; w++) rd(w, 1'b1, "R2");
    sweep(32'h0000_0000, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule